// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel I/O Port

This block is an 8-bit general-purpose I/O port that sits at one bus address. Each pin has one storage bit, and that bit sets both the direction and the level. A stored 0 sinks the pin to ground. A stored 1 lets the pin go, so an external pull-up raises it unless something outside holds it low. Software drives a pin low by writing 0. It turns a pin into an input by writing 1. A read always returns the live, synchronised level of the pins and never the stored bits.

Each pin is presented as three signals: an enable for the pad driver, the value that driver puts out, and the sampled pad level. These model an open-drain pad with a pull-up. When a stored bit goes from 0 to 1, the pin is driven high for a few clock cycles to charge the board capacitance. After that the driver lets go.

Each bit runs a small state machine with three states:
- `BIT_RELEASED`: the driver is off.
- `BIT_SINK`: the pin is driven low.
- `BIT_BOOST`: the pin is driven high for a counted number of cycles.

The transitions are:
- *sink*: a write of 0 from `BIT_RELEASED` or `BIT_BOOST` goes to `BIT_SINK`.
- *release-with-boost*: a write of 1 from `BIT_SINK` goes to `BIT_BOOST` and loads the counter.
- *boost-expire*: when the counter reaches zero in `BIT_BOOST`, the bit goes to `BIT_RELEASED`.
- *hold*: every other case leaves the state unchanged. In `BIT_BOOST` the counter keeps counting down.

Top module: `qbio_port`

## Requirements
- R1: After reset, every pin is released: `pad_oe` = 0x00, `pad_out` = 0x00 and `rdata` = 0x00. All stored bits are 1.
- R2: A write (`cs`=1, `wr`=1) with a 0 in bit i makes `pad_oe[i]`=1 and `pad_out[i]`=0 from the next cycle onward.
- R3: A write of 1 to a bit whose stored value is 0 gives `pad_oe[i]`=1 and `pad_out[i]`=1 for exactly PULSE_CYCLES cycles (default 2), starting the cycle after the write. After that, `pad_oe[i]`=0.
- R4: A write of 1 to a bit that is already released produces no high drive: `pad_oe[i]` stays 0.
- R5: A write of 0 to a bit that is in its high-drive window ends that window at once. The next cycle shows `pad_oe[i]`=1 and `pad_out[i]`=0.
- R6: A read (`cs`=1, `rd`=1) loads `rdata` at the next clock edge with the pad levels as seen through a two-stage synchroniser. A bit stored as 0 reads 0. A released bit reads the external level.
- R7: Writes take effect only when `cs`=1, so a write strobe with `cs`=0 is ignored. `rdata` keeps its value in every cycle without a read.
- R8: A write of 1 to a bit that is already in its high-drive window does not restart the window. The window still ends PULSE_CYCLES cycles after the write that began it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select for the single port address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data; one bit per pin |
| rdata | output | 8 | Registered read data, holding the synchronised pin levels |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_out | output | 8 | Per-pin driven value (1 only during the high-drive window) |
| pad_in | input | 8 | Sampled pad level for each pin |

## Verification
The hardest case to reach is a write that lands inside a bit's short high-drive window. That window lasts only two cycles, so a 0 must come on the very next cycle (R5), or a 1 must come in the last window cycle (R8). Directed sequences place writes back to back to hit both cases on chosen bits. A long random run then issues writes on most cycles, so other bits hit the window with arbitrary data. A cycle-accurate bench model follows each bit's stored value and window count, and the run compares the pad outputs and read data against that model on every cycle.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
    typedef enum logic [1:0] {
        BIT_RELEASED = 2'd0,
        BIT_SINK     = 2'd1,
        BIT_BOOST    = 2'd2
    } bit_state_e;
endpackage

// File: rtl/qbio_sync.sv
module qbio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/qbio_bit_cell.sv
module qbio_bit_cell
    import qbio_pkg::*;
#(
    parameter int PULSE_CYCLES = 2,
    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic drv_en,
    output logic drv_val
);
    bit_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BIT_RELEASED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BIT_RELEASED: begin
                if (wr_en && !wr_bit) state_d = BIT_SINK;
            end
            BIT_SINK: begin
                if (wr_en && wr_bit) begin
                    state_d = BIT_BOOST;
                    cnt_d   = CNT_W'(PULSE_CYCLES - 1);
                end
            end
            BIT_BOOST: begin
                if (wr_en && !wr_bit) begin
                    state_d = BIT_SINK;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin
                    state_d = BIT_RELEASED;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = BIT_RELEASED;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        drv_en  = (state_q != BIT_RELEASED);
        drv_val = (state_q == BIT_BOOST);
    end

    p_sink_after_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit) |=> (drv_en && !drv_val));

    p_boost_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit && state_q == BIT_SINK) |=> (drv_en && drv_val));

    p_no_boost_from_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit && state_q == BIT_RELEASED) |=> !drv_en);

    p_boost_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BIT_BOOST && cnt_q == '0 && !(wr_en && !wr_bit)) |=> !drv_en);

    p_boost_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BIT_BOOST) |-> (int'(cnt_q) <= PULSE_CYCLES - 1));
endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
    parameter int WIDTH        = 8,
    parameter int PULSE_CYCLES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             rd,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    input  logic [WIDTH-1:0] pad_in
);
    logic             wr_en;
    logic             rd_en;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] rdata_q;

    assign wr_en = cs && wr;
    assign rd_en = cs && rd;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        qbio_bit_cell #(.PULSE_CYCLES(PULSE_CYCLES)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_bit  (wdata[i]),
            .drv_en  (pad_oe[i]),
            .drv_val (pad_out[i])
        );
    end

    qbio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= pin_sync;
    end

    assign rdata = rdata_q;

    p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata == $past(pin_sync)));

    p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_drive_high_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));
endmodule

// File: tb/qbio_port_test.sv
module qbio_port_test;
    localparam int W     = 8;
    localparam int PULSE = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata, pad_oe, pad_out, pad_in;
    logic [W-1:0] ext = '1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    qbio_port #(.WIDTH(W), .PULSE_CYCLES(PULSE), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .wdata(wdata),
        .rdata(rdata), .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in)
    );

    logic [W-1:0] m_latch, m_s1, m_s2, m_rdata;
    int           m_boost [W];

    function automatic logic [W-1:0] exp_oe();
        logic [W-1:0] v = ~m_latch;
        for (int i = 0; i < W; i++) if (m_boost[i] > 0) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [W-1:0] exp_out();
        logic [W-1:0] v = '0;
        for (int i = 0; i < W; i++) if (m_boost[i] > 0) v[i] = 1'b1;
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_latch = '1; m_s1 = '1; m_s2 = '1; m_rdata = '0;
            for (int i = 0; i < W; i++) m_boost[i] = 0;
        end else begin
            logic [W-1:0] pin_now;
            pin_now = (exp_oe() & exp_out()) | (~exp_oe() & ext);
            if (cs && rd) m_rdata = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_now;
            for (int i = 0; i < W; i++) begin
                if (cs && wr) begin
                    if (!wdata[i]) begin
                        m_latch[i] = 1'b0; m_boost[i] = 0;
                    end else if (!m_latch[i]) begin
                        m_latch[i] = 1'b1; m_boost[i] = PULSE;
                    end else if (m_boost[i] > 0) begin
                        m_boost[i] = m_boost[i] - 1;
                    end
                end else if (m_boost[i] > 0) begin
                    m_boost[i] = m_boost[i] - 1;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2/R3/R5 model pad_oe", pad_oe, exp_oe());
            check("R3 model pad_out", pad_out, exp_out());
            check("R6/R7 model rdata", rdata, m_rdata);
        end
    end

    task automatic step(input logic c, input logic r, input logic w, input logic [W-1:0] d);
        cs = c; rd = r; wr = w; wdata = d;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240617));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset pad_oe", pad_oe, 8'h00);
        check("R1 reset pad_out", pad_out, 8'h00);
        check("R1 reset rdata", rdata, 8'h00);

        step(1, 0, 1, 8'h00);
        check("R2 sink oe", pad_oe, 8'hFF);
        check("R2 sink out", pad_out, 8'h00);

        step(1, 0, 1, 8'hFF);
        check("R3 boost c1 out", pad_out, 8'hFF);
        step(0, 0, 0, 8'h00);
        check("R3 boost c2 out", pad_out, 8'hFF);
        step(0, 0, 0, 8'h00);
        check("R3 boost end oe", pad_oe, 8'h00);

        step(1, 0, 1, 8'hFF);
        check("R4 no boost oe", pad_oe, 8'h00);

        step(1, 0, 1, 8'h00);
        step(1, 0, 1, 8'h0F);
        check("R3 partial out", pad_out, 8'h0F);
        step(1, 0, 1, 8'h0F);
        check("R8 window c2 out", pad_out, 8'h0F);
        step(0, 0, 0, 8'h00);
        check("R8 no restart oe", pad_oe, 8'hF0);
        check("R8 no restart out", pad_out, 8'h00);

        step(1, 0, 1, 8'hFF);
        step(1, 0, 1, 8'h0F);
        check("R5 abort oe", pad_oe, 8'hF0);
        check("R5 abort out", pad_out, 8'h00);

        step(0, 0, 1, 8'h00);
        check("R7 no cs write", pad_oe, 8'hF0);

        ext = 8'hA5;
        repeat (3) step(0, 0, 0, 8'h00);
        step(1, 1, 0, 8'h00);
        check("R6 read live pins", rdata, 8'h05);
        ext = 8'h0A;
        repeat (3) step(0, 1, 0, 8'h00);
        check("R7 rdata held", rdata, 8'h05);
        step(1, 1, 0, 8'h00);
        check("R6 read new level", rdata, 8'h0A);

        for (int n = 0; n < 4000; n++) begin
            logic [W-1:0] d;
            if ((n % 7) == 0) ext = W'($urandom);
            case ($urandom_range(0, 3))
                0: d = 8'h00;
                1: d = 8'hFF;
                default: d = W'($urandom);
            endcase
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, d);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule